// File: doc/BRIEF.md
# Mode-banked processor register file

This block holds the architectural registers of a 32-bit load/store processor core. Software always sees sixteen 32-bit registers, indexed 0 to 15. Index 15 is the program counter. Indices 0 to 12 are common to every operating mode. Indices 13 and 14 are backed by one physical copy per mode bank. When the core changes mode, the visible copies of 13 and 14 change with it, so a handler has its own stack pointer and link value without saving anything.

Each exception mode also has a saved status register. When the mode changes into an exception mode, the status word currently presented on `statusIn` is captured into that mode's saved register. The handler can read it back, or write it, through the saved-status port. The block holds the current mode itself. Mode changes arrive as a load strobe with the new 5-bit mode code.

The surrounding core supplies register addresses, write data, the program-counter increment strobe and the current status word. The block returns two combinational read values, the program counter, the current mode and the saved status for the current mode.

Top module: `mode_bank_regfile`

## Requirements
- R1: Indices 0 to 12 name registers shared by all modes: a value written in one mode reads back unchanged after any sequence of mode changes. Both read ports return the same register for the same index.
- R2: Indices 13 and 14 select one of six banks, chosen by the current mode: user/system, fast interrupt, interrupt, supervisor, abort and undefined. System mode uses the user copies. A write in one bank is not visible from another bank.
- R3: Reading index 15 on either port returns the program counter, which is also driven on `pcOut`. A write to index 15 loads the program counter at the clock edge.
- R4: When `pcInc` is high, the program counter advances by PC_STEP (4) at the edge. If a write to index 15 happens in the same cycle, the written value wins. With neither, the program counter holds.
- R5: Mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Loading any other code makes `curMode` read 10000 and selects the user bank.
- R6: A mode load whose target is an exception mode (fast interrupt, interrupt, supervisor, abort or undefined) copies `statusIn` into that mode's saved status register at the edge. In that mode, `spsrRdData` returns it. In an exception mode, `spsrWe` overwrites the current mode's saved status.
- R7: In user or system mode, `spsrRdData` equals `statusIn`, and `spsrWe` has no effect.
- R8: Reads are combinational and use the current mode. Register writes, mode loads, the increment and status saves all take effect at the rising clock edge. A register write in the same cycle as a mode load goes to the bank of the old mode.
- R9: A synchronous active-high `rst` clears every register and saved status, sets the program counter to 0 and sets the mode to supervisor (10011).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdAddrA | input | 4 | Read port A index |
| rdDataA | output | 32 | Read port A value |
| rdAddrB | input | 4 | Read port B index |
| rdDataB | output | 32 | Read port B value |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write index |
| wrData | input | 32 | Register write value |
| pcInc | input | 1 | Advance program counter by PC_STEP |
| pcOut | output | 32 | Current program counter |
| modeWe | input | 1 | Load a new mode |
| modeNext | input | 5 | Mode code to load |
| curMode | output | 5 | Current mode code |
| statusIn | input | 32 | Current status word from the core |
| spsrWe | input | 1 | Write the current mode's saved status |
| spsrWrData | input | 32 | Saved status write value |
| spsrRdData | output | 32 | Saved status of the current mode, or statusIn in user/system |

## Verification
The hardest case to reach from the ports is proving that banks stay apart. Registers 13 and 14 of one bank are only visible while that bank's mode is current. The stimulus therefore fills the supervisor, user and interrupt copies with distinct values. It then walks the mode through user, system, interrupt and back to supervisor, reading 13 and 14 after each step. The saved status cannot be read without re-entering its mode, and entering the mode overwrites it. So the bench changes `statusIn` before each entry and expects the newest value, then writes the saved status inside the mode and reads it back before leaving.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } modeE;

  localparam int NUM_REGS   = 16;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int NUM_SHARED = 13;
  localparam int NUM_BANKS  = 6;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam logic [IDX_W-1:0] IDX_SP = 4'd13;
  localparam logic [IDX_W-1:0] IDX_LR = 4'd14;
  localparam logic [IDX_W-1:0] IDX_PC = 4'd15;

  // bank 0 is user/system; banks 1..5 own a saved status register
  function automatic logic [BANK_W-1:0] bankOf(input logic [4:0] m);
    case (m)
      MODE_FIQ: return BANK_W'(1);
      MODE_IRQ: return BANK_W'(2);
      MODE_SVC: return BANK_W'(3);
      MODE_ABT: return BANK_W'(4);
      MODE_UND: return BANK_W'(5);
      default:  return BANK_W'(0);
    endcase
  endfunction

  function automatic logic isLegal(input logic [4:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  typedef struct packed {
    logic              wrShared;
    logic              wrBanked;
    logic              wrPc;
    logic              incPc;
    logic [IDX_W-1:0]  wrIdx;
    logic [BANK_W-1:0] curBank;
    logic              saveEn;
    logic [BANK_W-1:0] saveBank;
    logic              spsrWe;
  } strobeT;

endpackage

// File: rtl/mbrf_ctrl.sv
module mbrf_ctrl
  import mbrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic             pcInc,
  input  logic             modeWe,
  input  logic [4:0]       modeNext,
  input  logic             spsrWe,
  output logic [4:0]       curMode,
  output strobeT           st
);

  logic [4:0]        modeQ;
  logic [4:0]        modeD;
  logic [BANK_W-1:0] nextBank;

  always_comb begin
    modeD    = isLegal(modeNext) ? modeNext : MODE_USR;
    nextBank = bankOf(modeD);
  end

  always_ff @(posedge clk) begin
    if (rst)         modeQ <= MODE_SVC;
    else if (modeWe) modeQ <= modeD;
  end

  assign curMode = modeQ;

  always_comb begin
    st          = '0;
    st.wrIdx    = wrAddr;
    st.curBank  = bankOf(modeQ);
    st.wrShared = wrEn && (wrAddr < IDX_W'(NUM_SHARED));
    st.wrBanked = wrEn && ((wrAddr == IDX_SP) || (wrAddr == IDX_LR));
    st.wrPc     = wrEn && (wrAddr == IDX_PC);
    st.incPc    = pcInc;
    st.saveEn   = modeWe && (nextBank != '0);
    st.saveBank = nextBank;
    st.spsrWe   = spsrWe && (bankOf(modeQ) != '0);
  end

endmodule

// File: rtl/mbrf_datapath.sv
module mbrf_datapath
  import mbrf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4,
  parameter int NPORTS  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobeT                        st,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NPORTS-1:0][IDX_W-1:0]  rdAddr,
  output logic [NPORTS-1:0][DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0]             statusIn,
  input  logic [DATA_W-1:0]             spsrWrData,
  output logic [DATA_W-1:0]             spsrRdData,
  output logic [DATA_W-1:0]             pcOut
);

  logic [DATA_W-1:0] sharedQ [NUM_SHARED];
  logic [DATA_W-1:0] spQ     [NUM_BANKS];
  logic [DATA_W-1:0] lrQ     [NUM_BANKS];
  logic [DATA_W-1:0] savedQ  [NUM_BANKS];
  logic [DATA_W-1:0] pcQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SHARED; i++) sharedQ[i] <= '0;
    end else if (st.wrShared) begin
      sharedQ[st.wrIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        spQ[b] <= '0;
        lrQ[b] <= '0;
      end
    end else if (st.wrBanked) begin
      if (st.wrIdx == IDX_SP) spQ[st.curBank] <= wrData;
      else                    lrQ[st.curBank] <= wrData;
    end
  end

  // bank 0 has no saved status; its slot stays zero
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BANKS; b++) savedQ[b] <= '0;
    end else begin
      for (int b = 1; b < NUM_BANKS; b++) begin
        if (st.saveEn && st.saveBank == BANK_W'(b))
          savedQ[b] <= statusIn;
        else if (st.spsrWe && st.curBank == BANK_W'(b))
          savedQ[b] <= spsrWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           pcQ <= '0;
    else if (st.wrPc)  pcQ <= wrData;
    else if (st.incPc) pcQ <= pcQ + DATA_W'(PC_STEP);
  end

  assign pcOut = pcQ;

  for (genvar p = 0; p < NPORTS; p++) begin : gRead
    always_comb begin
      if (rdAddr[p] == IDX_PC)      rdData[p] = pcQ;
      else if (rdAddr[p] == IDX_LR) rdData[p] = lrQ[st.curBank];
      else if (rdAddr[p] == IDX_SP) rdData[p] = spQ[st.curBank];
      else                          rdData[p] = sharedQ[rdAddr[p]];
    end
  end

  always_comb begin
    if (st.curBank == '0) spsrRdData = statusIn;
    else                  spsrRdData = savedQ[st.curBank];
  end

endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
  import mbrf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcInc,
  output logic [DATA_W-1:0] pcOut,
  input  logic              modeWe,
  input  logic [4:0]        modeNext,
  output logic [4:0]        curMode,
  input  logic [DATA_W-1:0] statusIn,
  input  logic              spsrWe,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] spsrRdData
);

  strobeT                   st;
  logic [1:0][IDX_W-1:0]    rdAddr;
  logic [1:0][DATA_W-1:0]   rdData;

  assign rdAddr  = {rdAddrB, rdAddrA};
  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  mbrf_ctrl uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .pcInc(pcInc),
    .modeWe(modeWe), .modeNext(modeNext), .spsrWe(spsrWe),
    .curMode(curMode), .st(st)
  );

  mbrf_datapath #(.DATA_W(DATA_W), .PC_STEP(PC_STEP), .NPORTS(2)) uDp (
    .clk(clk), .rst(rst), .st(st), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .statusIn(statusIn),
    .spsrWrData(spsrWrData), .spsrRdData(spsrRdData), .pcOut(pcOut)
  );

endmodule

// File: rtl/mbrf_checker.sv
module mbrf_checker #(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              wrEn,
  input logic [3:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              pcInc,
  input logic [DATA_W-1:0] pcOut,
  input logic              modeWe,
  input logic [4:0]        modeNext,
  input logic [4:0]        curMode,
  input logic [DATA_W-1:0] statusIn,
  input logic [DATA_W-1:0] spsrRdData
);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (curMode == 5'b10011 && pcOut == '0));

  // R3
  pc_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 4'd15) |=> pcOut == $past(wrData));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pcInc && !(wrEn && wrAddr == 4'd15)) |=> pcOut == $past(pcOut) + DATA_W'(PC_STEP));

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pcInc && !(wrEn && wrAddr == 4'd15)) |=> $stable(pcOut));

  // R3
  pc_read_chk: assert property (@(posedge clk) disable iff (rst)
    rdAddrA == 4'd15 |-> rdDataA == pcOut);

  // R6
  irq_save_chk: assert property (@(posedge clk) disable iff (rst)
    (modeWe && modeNext == 5'b10010) |=> spsrRdData == $past(statusIn));

  // R7
  user_spsr_chk: assert property (@(posedge clk) disable iff (rst)
    (curMode == 5'b10000 || curMode == 5'b11111) |-> spsrRdData == statusIn);

  // R5
  legal_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (modeWe && !(modeNext inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                  5'b10111, 5'b11011, 5'b11111}))
      |=> curMode == 5'b10000);

endmodule

bind mode_bank_regfile mbrf_checker #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) uChk (
  .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .pcInc(pcInc), .pcOut(pcOut),
  .modeWe(modeWe), .modeNext(modeNext), .curMode(curMode),
  .statusIn(statusIn), .spsrRdData(spsrRdData)
);

// File: tb/tb_mode_bank_regfile.sv
module tb_mode_bank_regfile;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData, pcOut, statusIn, spsrWrData, spsrRdData;
  logic        wrEn, pcInc, modeWe, spsrWe;
  logic [4:0]  modeNext, curMode;

  always #10 clk = ~clk;

  mode_bank_regfile dut (
    .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pcInc(pcInc), .pcOut(pcOut), .modeWe(modeWe),
    .modeNext(modeNext), .curMode(curMode), .statusIn(statusIn),
    .spsrWe(spsrWe), .spsrWrData(spsrWrData), .spsrRdData(spsrRdData)
  );

  // what the scoreboard compares: 0 port A, 1 port B, 2 pcOut, 3 saved status, 4 mode
  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } itemT;

  itemT queueQ[$];
  int   checks = 0;
  int   errors = 0;
  event chkEv;

  function automatic logic [31:0] observe(input int sel);
    case (sel)
      0: return rdDataA;
      1: return rdDataB;
      2: return pcOut;
      3: return spsrRdData;
      default: return {27'd0, curMode};
    endcase
  endfunction

  initial begin
    forever begin
      @(chkEv);
      while (queueQ.size() > 0) begin
        itemT it;
        logic [31:0] act;
        it = queueQ.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expectVal(input int sel, input logic [3:0] addr,
                           input logic [31:0] exp, input string tag);
    @(negedge clk);
    if (sel == 1) rdAddrB = addr; else rdAddrA = addr;
    #1;
    queueQ.push_back('{sel, exp, tag});
    ->chkEv;
    #1;
  endtask

  task automatic idle();
    wrEn = 0; pcInc = 0; modeWe = 0; spsrWe = 0;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d, input logic inc);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d; pcInc = inc;
    @(posedge clk); #1 idle();
  endtask

  task automatic setMode(input logic [4:0] m, input logic [31:0] s);
    @(negedge clk);
    modeWe = 1; modeNext = m; statusIn = s;
    @(posedge clk); #1 idle();
  endtask

  task automatic bumpPc();
    @(negedge clk);
    pcInc = 1;
    @(posedge clk); #1 idle();
  endtask

  task automatic writeSaved(input logic [31:0] d);
    @(negedge clk);
    spsrWe = 1; spsrWrData = d;
    @(posedge clk); #1 idle();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<5000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    idle();
    rst = 1; rdAddrA = 0; rdAddrB = 0; wrAddr = 0; wrData = 0;
    modeNext = 5'b10011; statusIn = 0; spsrWrData = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R9 reset state
    expectVal(4, 0, 32'h13, "R9 mode after reset");
    expectVal(2, 0, 0, "R9 pc after reset");
    expectVal(0, 4'd7, 0, "R9 r7 after reset");
    expectVal(3, 0, 0, "R9 saved status after reset");

    // R1 shared registers, R8 write at edge
    writeReg(4'd3, 32'hA5A5_0003, 0);
    writeReg(4'd12, 32'h0000_C0DE, 0);
    expectVal(0, 4'd3, 32'hA5A5_0003, "R1 r3 port A");
    expectVal(1, 4'd3, 32'hA5A5_0003, "R1 r3 port B");
    expectVal(1, 4'd12, 32'h0000_C0DE, "R8 r12 port B");

    // R2 banks
    writeReg(4'd13, 32'h5555_0013, 0);
    writeReg(4'd14, 32'h5555_0014, 0);
    setMode(5'b10000, 32'h0);
    expectVal(0, 4'd13, 0, "R2 user sp distinct from supervisor");
    expectVal(1, 4'd14, 0, "R2 user lr distinct from supervisor");
    writeReg(4'd13, 32'h1111_0013, 0);
    setMode(5'b11111, 32'h0);
    expectVal(0, 4'd13, 32'h1111_0013, "R2 system shares user sp");
    expectVal(3, 0, 32'h0, "R7 system saved status is statusIn");

    // R6 save on entry to interrupt
    setMode(5'b10010, 32'h0000_001F);
    expectVal(4, 0, 32'h12, "R5 interrupt code");
    expectVal(0, 4'd13, 0, "R2 interrupt sp own copy");
    expectVal(3, 0, 32'h0000_001F, "R6 interrupt saved status");
    expectVal(1, 4'd3, 32'hA5A5_0003, "R1 r3 visible in interrupt");
    statusIn = 32'hFFFF_0000;
    expectVal(3, 0, 32'h0000_001F, "R6 saved status holds while statusIn moves");
    writeSaved(32'h0BAD_F00D);
    expectVal(3, 0, 32'h0BAD_F00D, "R6 saved status write in interrupt");

    // R8 write with simultaneous mode load goes to old bank
    @(negedge clk);
    wrEn = 1; wrAddr = 4'd14; wrData = 32'h2222_0014;
    modeWe = 1; modeNext = 5'b10011; statusIn = 32'h0000_0055;
    @(posedge clk); #1 idle();
    expectVal(0, 4'd13, 32'h5555_0013, "R2 supervisor sp retained");
    expectVal(1, 4'd14, 32'h5555_0014, "R8 supervisor lr untouched by same-cycle write");
    expectVal(3, 0, 32'h0000_0055, "R6 supervisor saved status on entry");
    setMode(5'b10010, 32'h0000_0077);
    expectVal(1, 4'd14, 32'h2222_0014, "R8 interrupt lr got same-cycle write");

    // R3 / R4 program counter
    writeReg(4'd15, 32'h0000_0100, 0);
    expectVal(0, 4'd15, 32'h0000_0100, "R3 read index 15");
    expectVal(2, 0, 32'h0000_0100, "R3 pcOut after write");
    bumpPc();
    expectVal(2, 0, 32'h0000_0104, "R4 increment");
    writeReg(4'd15, 32'h0000_0200, 1);
    expectVal(1, 4'd15, 32'h0000_0200, "R4 write beats increment");
    expectVal(2, 0, 32'h0000_0200, "R4 pc holds when idle");

    // R7 user mode saved status
    setMode(5'b10000, 32'h0000_00AA);
    writeSaved(32'hDEAD_BEEF);
    expectVal(3, 0, 32'h0000_00AA, "R7 user write ignored, reads statusIn");

    // R5 unknown code
    setMode(5'b00000, 32'h0);
    expectVal(4, 0, 32'h10, "R5 unknown code becomes user");
    expectVal(0, 4'd13, 32'h1111_0013, "R5 unknown code uses user bank");
    setMode(5'b10111, 32'h0000_0ABC);
    expectVal(4, 0, 32'h17, "R5 abort code");
    expectVal(3, 0, 32'h0000_0ABC, "R6 abort saved status");

    // R9 reset mid-run
    @(negedge clk); rst = 1;
    @(posedge clk); #1 rst = 0;
    expectVal(0, 4'd3, 0, "R9 r3 cleared");
    expectVal(4, 0, 32'h13, "R9 supervisor after reset");
    expectVal(1, 4'd13, 0, "R9 supervisor sp cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule